// File: doc/BRIEF.md
# Write-Through Data Cache with Store Queue

A direct-mapped data cache for a processor's load/store port. Each line holds a single 32-bit word, so every store simply overwrites the indexed line with its tag, word and a set valid bit. There is no tag check, no fetch of the line and no dirty state. Every store is also placed in a small FIFO in front of main memory, and the FIFO writes its entries out one at a time. The processor therefore waits on a store only when the queue is full, not for each slow memory write.

A load that hits returns its word in the same cycle. A load that misses holds the processor stalled until the queue is empty and any write in flight has finished. It then reads the word from memory using the load's full address, fills the line, and completes in the following cycle. Waiting for the queue to empty means a word that was evicted from the cache but not yet written out can never be returned stale.

The requester holds `cpu_req_i` and its operands until it sees `cpu_stall_o` low. The operation completes at the rising clock edge of the cycle in which the request is high and the stall is low. The memory port holds a request until `mem_ack_i` is pulsed. For a read, the word arrives on `mem_rdata_i` in that same ack cycle.

Top module: `wt_dcache`

## Requirements
- R1: After reset, every line is invalid, `cpu_stall_o` is low whenever `cpu_req_i` is low, and no memory request is raised. The first load to any address therefore misses.
- R2: The line index is address bits [IDX_W+1:2] and the tag is bits [31:IDX_W+2]; the default IDX_W=6 gives index [7:2] and tag [31:8]. Two addresses that differ only in the top index bit occupy separate lines. Two addresses that share an index but differ in any tag bit, including bit 31, conflict.
- R3: A store, hit or miss, writes the tag and the word into the indexed line and sets its valid bit. A later load of the same address hits and returns that word.
- R4: A store is accepted in its first cycle while the queue holds fewer than WB_DEPTH (4) entries. With four entries pending, it stalls until an entry retires.
- R5: Each accepted store queues its full address and word. Memory writes are issued one at a time, in acceptance order, with address, data and write flag held stable until `mem_ack_i`; each ack retires one entry.
- R6: A load whose indexed line is valid with a matching tag completes without stalling, with `cpu_rdata_o` carrying the stored word in that cycle.
- R7: A load miss stalls. No memory read is issued until the store queue is empty, so a read never overtakes a pending write to the same address.
- R8: On the read ack, the fetched word, tag and valid bit are written into the line. The load completes in the next cycle with the fetched word, and repeat loads of that address hit.
- R9: A store to an index that holds a different tag replaces the line, so a later load of the old address misses and is served from memory with its current word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | Load/store request, held until accepted |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | 32 | Byte address (word aligned) |
| cpu_wdata_i | input | 32 | Store word |
| cpu_rdata_o | output | 32 | Load word, valid in the accept cycle |
| cpu_stall_o | output | 1 | Request cannot complete this cycle |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write from queue, 0 = miss read |
| mem_addr_o | output | 32 | Full memory address |
| mem_wdata_o | output | 32 | Write word |
| mem_ack_i | input | 1 | One-cycle completion of the current access |
| mem_rdata_i | input | 32 | Read word, valid with the ack |

## Verification
Cold loads show that reset clears every valid bit. Loads repeated after a fill or after a store tell a real hit (no stall) apart from a refill. Stores to a busy index with a new tag, with a tag differing only in bit 31, and with addresses differing only in the top index bit show where the index ends and the tag begins. Five back-to-back stores separate "accept while room" from "stall when full". A store pair to one index followed by a load of the evicted address, with the queue still busy, tells a drained read apart from a read that would return stale memory. A scoreboard also compares every memory write against the order in which the stores were accepted.

// File: rtl/wt_dcache_pkg.sv
package wt_dcache_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wb_entry_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } ctrl_state_e;
endpackage

// File: rtl/wt_dcache_array.sv
module wt_dcache_array #(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned TAG_W  = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int unsigned LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  // only valid bits need reset; tag/data are qualified by them
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      data_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_data_o  = data_q[rd_idx_i];
endmodule

// File: rtl/wt_dcache_wbuf.sv
module wt_dcache_wbuf
  import wt_dcache_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  wb_entry_t        push_entry_i,
  input  logic             pop_i,
  output wb_entry_t        head_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  wb_entry_t        slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_FULL);
  assign count_o = cnt_q;
  assign head_o  = slot_q[rd_ptr_q];
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) slot_q[wr_ptr_q] <= push_entry_i;
  end
endmodule

// File: rtl/wt_dcache_ctrl.sv
module wt_dcache_ctrl
  import wt_dcache_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic we_i,
  input  logic hit_i,
  input  logic wb_empty_i,
  input  logic wb_full_i,
  input  logic rd_ack_i,
  output logic stall_o,
  output logic store_o,
  output logic fetch_start_o,
  output logic fetch_o,
  output logic fill_o
);
  ctrl_state_e state_q, state_d;

  assign fetch_o       = (state_q == ST_FETCH);
  assign stall_o       = req_i & (fetch_o | (we_i ? wb_full_i : ~hit_i));
  assign store_o       = req_i & we_i & ~wb_full_i & ~fetch_o;
  // miss read waits for an empty queue: no stale word, no port conflict
  assign fetch_start_o = req_i & ~we_i & ~hit_i & wb_empty_i & ~fetch_o;
  assign fill_o        = fetch_o & rd_ack_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (fetch_start_o) state_d = ST_FETCH;
      ST_FETCH: if (rd_ack_i)      state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/wt_dcache.sv
module wt_dcache
  import wt_dcache_pkg::*;
#(
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned WB_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_stall_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int unsigned TAG_W    = ADDR_W - IDX_W - 2;
  localparam int unsigned WB_CNT_W = $clog2(WB_DEPTH + 1);

  logic [IDX_W-1:0]  cpu_idx, miss_idx, arr_wr_idx;
  logic [TAG_W-1:0]  cpu_tag, miss_tag, arr_wr_tag, rd_tag;
  logic [DATA_W-1:0] rd_data, arr_wr_data;
  logic              rd_valid, hit, arr_wr_en;
  logic [ADDR_W-1:0] miss_addr_q;

  logic              stall, store, fetch_start, fetch, fill;
  wb_entry_t         wb_push_entry, wb_head;
  logic              wb_empty, wb_full, wb_pop;
  logic [WB_CNT_W-1:0] wb_count;

  assign cpu_idx  = cpu_addr_i[IDX_W+1:2];
  assign cpu_tag  = cpu_addr_i[ADDR_W-1:IDX_W+2];
  assign miss_idx = miss_addr_q[IDX_W+1:2];
  assign miss_tag = miss_addr_q[ADDR_W-1:IDX_W+2];
  assign hit      = rd_valid & (rd_tag == cpu_tag);

  // fill and store never coincide: the CPU is parked on the load
  assign arr_wr_en   = store | fill;
  assign arr_wr_idx  = fill ? miss_idx    : cpu_idx;
  assign arr_wr_tag  = fill ? miss_tag    : cpu_tag;
  assign arr_wr_data = fill ? mem_rdata_i : cpu_wdata_i;

  wt_dcache_array #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .DATA_W(DATA_W)
  ) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (cpu_idx),
    .rd_valid_o(rd_valid),
    .rd_tag_o  (rd_tag),
    .rd_data_o (rd_data),
    .wr_en_i   (arr_wr_en),
    .wr_idx_i  (arr_wr_idx),
    .wr_tag_i  (arr_wr_tag),
    .wr_data_i (arr_wr_data)
  );

  wt_dcache_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (cpu_req_i),
    .we_i         (cpu_we_i),
    .hit_i        (hit),
    .wb_empty_i   (wb_empty),
    .wb_full_i    (wb_full),
    .rd_ack_i     (mem_ack_i),
    .stall_o      (stall),
    .store_o      (store),
    .fetch_start_o(fetch_start),
    .fetch_o      (fetch),
    .fill_o       (fill)
  );

  assign wb_push_entry = '{addr: cpu_addr_i, data: cpu_wdata_i};
  assign wb_pop        = mem_ack_i & ~fetch;

  wt_dcache_wbuf #(
    .DEPTH(WB_DEPTH),
    .CNT_W(WB_CNT_W)
  ) u_wbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (store),
    .push_entry_i(wb_push_entry),
    .pop_i       (wb_pop),
    .head_o      (wb_head),
    .empty_o     (wb_empty),
    .full_o      (wb_full),
    .count_o     (wb_count)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          miss_addr_q <= '0;
    else if (fetch_start) miss_addr_q <= cpu_addr_i;
  end

  assign cpu_stall_o = stall;
  assign cpu_rdata_o = rd_data;
  assign mem_req_o   = fetch | ~wb_empty;
  assign mem_we_o    = ~fetch;
  assign mem_addr_o  = fetch ? miss_addr_q : wb_head.addr;
  assign mem_wdata_o = fetch ? '0 : wb_head.data;
endmodule

// File: rtl/wt_dcache_chk.sv
module wt_dcache_chk #(
  parameter int unsigned WB_DEPTH = 4,
  parameter int unsigned CNT_W    = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cpu_req_i,
  input logic             cpu_we_i,
  input logic             cpu_stall_o,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [31:0]      mem_addr_o,
  input logic [31:0]      mem_wdata_o,
  input logic             mem_ack_i,
  input logic [CNT_W-1:0] wb_count_i
);
  // R1
  idle_no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_req_i |-> !cpu_stall_o);

  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_count_i <= CNT_W'(WB_DEPTH));

  // R4
  store_stall_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_we_i && cpu_stall_o) |-> (wb_count_i == CNT_W'(WB_DEPTH)));

  // R5
  store_enqueue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_we_i && !cpu_stall_o && !(mem_ack_i && mem_req_o && mem_we_o))
    |=> (wb_count_i == $past(wb_count_i) + 1'b1));

  // R5
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o) && $stable(mem_wdata_o)));

  // R7
  read_after_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> (wb_count_i == '0));
endmodule

bind wt_dcache wt_dcache_chk #(
  .WB_DEPTH(WB_DEPTH),
  .CNT_W   (WB_CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpu_req_i  (cpu_req_i),
  .cpu_we_i   (cpu_we_i),
  .cpu_stall_o(cpu_stall_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_ack_i  (mem_ack_i),
  .wb_count_i (wb_count)
);

// File: tb/wt_dcache_bench.sv
`timescale 1ns/100ps
module wt_dcache_bench;
  localparam int WR_LAT = 10;
  localparam int RD_LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [31:0] rdata;
  logic        stall;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0;
  int errors = 0;

  logic [31:0] ref_mem [logic [31:0]];
  logic [31:0] bus_mem [logic [31:0]];
  logic [31:0] exp_rd_q [$];
  logic [63:0] exp_wr_q [$];

  always #2 clk = ~clk;

  wt_dcache u_wt_dcache (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(req), .cpu_we_i(we), .cpu_addr_i(addr), .cpu_wdata_i(wdata),
    .cpu_rdata_o(rdata), .cpu_stall_o(stall),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] init_word(input logic [31:0] a);
    return ~a ^ 32'h3C5A_96E1;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model: 10-cycle writes, short reads, one-cycle ack
  int lat_cnt = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      lat_cnt   <= 0;
    end else if (mem_req && !mem_ack) begin
      if (lat_cnt == (mem_we ? WR_LAT : RD_LAT) - 1) begin
        mem_ack <= 1'b1;
        lat_cnt <= 0;
        if (mem_we) bus_mem[mem_addr] = mem_wdata;
        else mem_rdata <= bus_mem.exists(mem_addr) ? bus_mem[mem_addr] : init_word(mem_addr);
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
      lat_cnt <= 0;
    end
  end

  // monitor: load results and memory write order
  initial forever begin
    @(negedge clk);
    #1;
    if (req && !we && !stall) begin
      if (exp_rd_q.size() == 0) check(1'b0, "R6/R8 unexpected load", rdata, '0);
      else begin
        logic [31:0] e;
        e = exp_rd_q.pop_front();
        check(rdata == e, "R6/R8 load data", rdata, e);
      end
    end
    if (mem_ack && mem_req && mem_we) begin
      if (exp_wr_q.size() == 0) check(1'b0, "R5 unexpected write", mem_addr, '0);
      else begin
        logic [63:0] w;
        w = exp_wr_q.pop_front();
        check(mem_addr == w[63:32], "R5 write address order", mem_addr, w[63:32]);
        check(mem_wdata == w[31:0], "R5 write data order", mem_wdata, w[31:0]);
      end
    end
  end

  // driver: pushes expectations, holds request until accepted
  task automatic op(input logic w, input logic [31:0] a, input logic [31:0] d,
                    output int stalls);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    if (w) begin
      exp_wr_q.push_back({a, d});
      ref_mem[a] = d;
    end else begin
      exp_rd_q.push_back(ref_mem.exists(a) ? ref_mem[a] : init_word(a));
    end
    stalls = 0;
    #0.5;
    while (stall) begin
      stalls++;
      @(negedge clk);
      #0.5;
    end
    @(posedge clk);
    #0.5;
    req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam logic [31:0] A0 = 32'h0000_1000;  // index 0
  localparam logic [31:0] A1 = 32'h0000_2044;  // index 17
  localparam logic [31:0] A2 = 32'h0000_1100;  // index 0, other tag
  localparam logic [31:0] A3 = 32'h0000_1080;  // top index bit set
  localparam logic [31:0] A4 = 32'h8000_1000;  // index 0, tag bit 31

  initial begin
    int s;
    #10;
    @(negedge clk);
    check(stall == 1'b0, "R1 stall after reset", {31'd0, stall}, 32'd0);
    check(mem_req == 1'b0, "R1 no mem request after reset", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;
    idle(2);

    op(1'b0, A0, '0, s);
    check(s > 0, "R1 cold load misses", s, 1);
    op(1'b0, A0, '0, s);
    check(s == 0, "R8 refill then hit", s, 0);

    op(1'b1, A0, 32'hDEAD_0001, s);
    check(s == 0, "R4 store with room", s, 0);
    op(1'b0, A0, '0, s);
    check(s == 0, "R3 load after store hit", s, 0);

    op(1'b1, A1, 32'hBEEF_0002, s);
    op(1'b0, A1, '0, s);
    check(s == 0, "R3 store miss allocates", s, 0);

    op(1'b1, A2, 32'hCAFE_0003, s);
    op(1'b0, A2, '0, s);
    check(s == 0, "R6 hit on replaced line", s, 0);
    op(1'b0, A0, '0, s);
    check(s > 0, "R9 evicted address misses", s, 1);

    idle(60);
    for (int i = 0; i < 5; i++) begin
      op(1'b1, 32'h0000_3000 + 32'(i * 4), 32'h5000_0000 + 32'(i), s);
      if (i < 4) check(s == 0, "R4 store accepted with room", s, 0);
      else       check(s > 0, "R4 store stalls when full", s, 1);
    end

    idle(60);
    op(1'b1, 32'h0000_4010, 32'h1111_AAAA, s);
    op(1'b1, 32'h0000_4110, 32'h2222_BBBB, s);
    op(1'b0, 32'h0000_4010, '0, s);
    check(s >= WR_LAT, "R7 miss waits for queued writes", s, WR_LAT);

    op(1'b1, A3, 32'h3333_0004, s);
    op(1'b1, A0, 32'h4444_0005, s);
    op(1'b0, A3, '0, s);
    check(s == 0, "R2 top index bit separates lines", s, 0);
    op(1'b0, A0, '0, s);
    check(s == 0, "R2 low index line kept", s, 0);
    op(1'b1, A4, 32'h5555_0006, s);
    op(1'b0, A0, '0, s);
    check(s > 0, "R2 bit 31 is a tag bit", s, 1);
    op(1'b0, A4, '0, s);
    check(s > 0, "R9 refill evicted tag-31 line", s, 1);

    for (int i = 0; i < 200 && exp_wr_q.size() != 0; i++) @(negedge clk);
    idle(2);
    check(exp_wr_q.size() == 0, "R5 all stores written", exp_wr_q.size(), 0);
    check(exp_rd_q.size() == 0, "R8 all loads completed", exp_rd_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule